// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level table held in ordinary memory. A base register points at the directory. The top ten address bits select a directory entry, the next ten select an entry in the second-level table that entry points to, and the low twelve bits pass through unchanged as the offset within a 4 KB page. Every table entry is one 32-bit word: a 20-bit frame number in bits 31:12 and flags in bits 11:0. The flag bits are present (0), writable (1), user (2), accessed (5) and dirty (6).

A request carries the linear address, a write flag and a user-mode flag. The walker checks both entries against that access. If both pass, it sets any accessed or dirty bits that are missing by writing the changed entries back to memory. It then returns the physical address. A failed check returns a fault with a three-bit cause instead, and memory is left unchanged.

The request, result and memory-request channels are valid/ready. A request is taken only while `req_ready` is high, which is only when the walker is idle. A result stays on the result channel with all its fields unchanged until `res_ready` is seen high. A memory request holds its address, write flag and data until `mem_req_ready` is high. Read data comes back on `mem_rsp_valid` and cannot be stalled. Writes get no response. The directory base is written through `root_wr_en`, and only a caller at ring 0 can change it.

Top module: `pt_walker`

## Requirements
- R1: The first memory access of every walk is a read of the word at the directory base plus four times bits 31:22 of the linear address.
- R2: When the directory entry passes its checks, the second read is at its frame number (bits 31:12) shifted left by 12, plus four times bits 21:12 of the linear address.
- R3: A walk that does not fault returns the physical address made of the second-level entry's bits 31:12 above bits 11:0 of the linear address.
- R4: An entry with the present bit (bit 0) clear, at either level, ends the walk with a fault.
- R5: A user-mode access to an entry with the user bit (bit 2) clear faults. A user-mode write to an entry with the writable bit (bit 1) clear faults. Supervisor accesses ignore both bits.
- R6: The fault cause is {user access, write access, present bit of the failing entry} in bits 2,1,0. The cause is zero on success.
- R7: On a successful walk, each entry with the accessed bit (bit 5) clear is written back with that bit set. A write access also sets the dirty bit (bit 6) of the second-level entry if it is clear. The directory entry is written before the table entry.
- R8: A faulting walk writes nothing to memory. An entry that already has the bits the access needs is not written.
- R9: The directory base changes on `root_wr_en` only when `cur_ring` is 0. Any other ring leaves it unchanged.
- R10: `req_ready` is high only while idle. A result holds `res_valid` and its fields stable until `res_ready`.
- R11: After reset, `req_ready` is 1, `res_valid` and `mem_req_valid` are 0, and the directory base is 0.
- R12: A memory request that is not accepted keeps its valid, address, write flag and data unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_wr_en | input | 1 | Write strobe for the directory base |
| root_wr_data | input | 32 | New directory base address |
| cur_ring | input | 2 | Privilege ring of the caller; 0 is most privileged |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 32 | Physical address (0 on fault) |
| res_fault | output | 1 | Walk ended in a page fault |
| res_cause | output | 3 | Fault cause {user, write, present} |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for a write-back, 0 for a read |
| mem_req_addr | output | 32 | Byte address of the entry word |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
A table of twelve translations is run against one fixed pair of tables. The table covers every combination of accessed and dirty state with read and write accesses, so the number of write-backs tells apart walks that update nothing, one entry or both. Faults appear at each level for a missing entry, a supervisor-only entry and a read-only entry, which checks that the cause bits follow the access and that no write leaks out before the fault. Supervisor writes to read-only entries tell privilege-aware checking apart from plain bit tests. Directed runs then look at the written-back words, root writes from rings 0 and 3, and a memory port and result consumer that stall.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int DIR_W  = 10;
  localparam int TBL_W  = 10;
  localparam int OFF_W  = 12;
  localparam int ADDR_W = DIR_W + TBL_W + OFF_W;
  localparam int ENT_SH = 2;
  localparam int FRM_W  = ADDR_W - OFF_W;
  localparam int CAUSE_W = 3;

  localparam int FL_PRESENT = 0;
  localparam int FL_WRITE   = 1;
  localparam int FL_USER    = 2;
  localparam int FL_ACCESS  = 5;
  localparam int FL_DIRTY   = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_WT_DIR, S_RD_TBL, S_WT_TBL, S_WB_DIR, S_WB_TBL, S_DONE
  } walk_state_t;
endpackage

// File: rtl/pt_root_reg.sv
module pt_root_reg
  import pt_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    ring,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] root_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) root_q <= '0;
    else if (wr_en && ring == 2'd0) root_q <= wr_data;
  end
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_pkg::*;
#(
  parameter int  AW   = ADDR_W,
  parameter bit  LEAF = 1'b0
) (
  input  logic [AW-1:0]      entry,
  input  logic               is_wr,
  input  logic               is_usr,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause,
  output logic               wb_need,
  output logic [AW-1:0]      wb_data
);
  logic [AW-1:0] set_mask;
  logic          dirty_miss;

  generate
    if (LEAF) begin : g_leaf
      always_comb begin
        set_mask = '0;
        set_mask[FL_ACCESS] = 1'b1;
        set_mask[FL_DIRTY]  = is_wr;
        dirty_miss = is_wr && !entry[FL_DIRTY];
      end
    end else begin : g_dir
      always_comb begin
        set_mask = '0;
        set_mask[FL_ACCESS] = 1'b1;
        dirty_miss = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    fault = !entry[FL_PRESENT]
          || (is_usr && !entry[FL_USER])
          || (is_usr && is_wr && !entry[FL_WRITE]);
    cause   = fault ? {is_usr, is_wr, entry[FL_PRESENT]} : '0;
    wb_need = !entry[FL_ACCESS] || dirty_miss;
    wb_data = entry | set_mask;
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  root,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [ADDR_W-1:0]  res_paddr,
  output logic               res_fault,
  output logic [CAUSE_W-1:0] res_cause,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_we,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [ADDR_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [FRM_W-1:0]   rsp_frame,
  output logic               acc_wr,
  output logic               acc_usr,
  input  logic               dir_fault,
  input  logic [CAUSE_W-1:0] dir_cause,
  input  logic               dir_wb_need,
  input  logic [ADDR_W-1:0]  dir_wb_data,
  input  logic               tbl_fault,
  input  logic [CAUSE_W-1:0] tbl_cause,
  input  logic               tbl_wb_need,
  input  logic [ADDR_W-1:0]  tbl_wb_data
);
  localparam int PAD_W = ADDR_W - DIR_W - ENT_SH;

  walk_state_t          state;
  logic [ADDR_W-1:0]    va_q;
  logic                 wr_q, usr_q;
  logic [FRM_W-1:0]     pde_frame_q;
  logic                 pde_wb_q, pte_wb_q;
  logic [ADDR_W-1:0]    pde_wbd_q, pte_wbd_q;
  logic                 fault_q;
  logic [CAUSE_W-1:0]   cause_q;
  logic [ADDR_W-1:0]    paddr_q;
  logic [ADDR_W-1:0]    dir_addr, tbl_addr;

  assign dir_addr = root + {{PAD_W{1'b0}}, va_q[ADDR_W-1 -: DIR_W], {ENT_SH{1'b0}}};
  assign tbl_addr = {pde_frame_q, va_q[OFF_W +: TBL_W], {ENT_SH{1'b0}}};
  assign acc_wr   = wr_q;
  assign acc_usr  = usr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      pde_frame_q <= '0;
      pde_wb_q    <= 1'b0;
      pte_wb_q    <= 1'b0;
      pde_wbd_q   <= '0;
      pte_wbd_q   <= '0;
      fault_q     <= 1'b0;
      cause_q     <= '0;
      paddr_q     <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          usr_q   <= req_user;
          fault_q <= 1'b0;
          cause_q <= '0;
          paddr_q <= '0;
          state   <= S_RD_DIR;
        end
        S_RD_DIR: if (mem_req_ready) state <= S_WT_DIR;
        S_WT_DIR: if (mem_rsp_valid) begin
          if (dir_fault) begin
            fault_q <= 1'b1;
            cause_q <= dir_cause;
            state   <= S_DONE;
          end else begin
            pde_frame_q <= rsp_frame;
            pde_wb_q    <= dir_wb_need;
            pde_wbd_q   <= dir_wb_data;
            state       <= S_RD_TBL;
          end
        end
        S_RD_TBL: if (mem_req_ready) state <= S_WT_TBL;
        S_WT_TBL: if (mem_rsp_valid) begin
          if (tbl_fault) begin
            fault_q <= 1'b1;
            cause_q <= tbl_cause;
            state   <= S_DONE;
          end else begin
            paddr_q   <= {rsp_frame, va_q[OFF_W-1:0]};
            pte_wb_q  <= tbl_wb_need;
            pte_wbd_q <= tbl_wb_data;
            if (pde_wb_q)         state <= S_WB_DIR;
            else if (tbl_wb_need) state <= S_WB_TBL;
            else                  state <= S_DONE;
          end
        end
        S_WB_DIR: if (mem_req_ready) state <= pte_wb_q ? S_WB_TBL : S_DONE;
        S_WB_TBL: if (mem_req_ready) state <= S_DONE;
        S_DONE:   if (res_ready) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (state == S_IDLE);
    res_valid     = (state == S_DONE);
    res_paddr     = paddr_q;
    res_fault     = fault_q;
    res_cause     = cause_q;
    mem_req_valid = (state == S_RD_DIR) || (state == S_RD_TBL) ||
                    (state == S_WB_DIR) || (state == S_WB_TBL);
    mem_req_we    = (state == S_WB_DIR) || (state == S_WB_TBL);
    mem_req_addr  = ((state == S_RD_DIR) || (state == S_WB_DIR)) ? dir_addr : tbl_addr;
    mem_req_wdata = (state == S_WB_DIR) ? pde_wbd_q :
                    (state == S_WB_TBL) ? pte_wbd_q : '0;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               root_wr_en,
  input  logic [ADDR_W-1:0]  root_wr_data,
  input  logic [1:0]         cur_ring,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [ADDR_W-1:0]  res_paddr,
  output logic               res_fault,
  output logic [CAUSE_W-1:0] res_cause,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_we,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [ADDR_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [ADDR_W-1:0]  mem_rsp_rdata
);
  logic [ADDR_W-1:0]  root_q;
  logic               acc_wr, acc_usr;
  logic               dir_fault, tbl_fault, dir_wb_need, tbl_wb_need;
  logic [CAUSE_W-1:0] dir_cause, tbl_cause;
  logic [ADDR_W-1:0]  dir_wb_data, tbl_wb_data;

  pt_root_reg #(.AW(ADDR_W)) u_root (
    .clk(clk), .rst_n(rst_n), .wr_en(root_wr_en), .ring(cur_ring),
    .wr_data(root_wr_data), .root_q(root_q)
  );

  pt_entry_check #(.AW(ADDR_W), .LEAF(1'b0)) u_chk_dir (
    .entry(mem_rsp_rdata), .is_wr(acc_wr), .is_usr(acc_usr),
    .fault(dir_fault), .cause(dir_cause),
    .wb_need(dir_wb_need), .wb_data(dir_wb_data)
  );

  pt_entry_check #(.AW(ADDR_W), .LEAF(1'b1)) u_chk_tbl (
    .entry(mem_rsp_rdata), .is_wr(acc_wr), .is_usr(acc_usr),
    .fault(tbl_fault), .cause(tbl_cause),
    .wb_need(tbl_wb_need), .wb_data(tbl_wb_data)
  );

  pt_walk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .root(root_q),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
    .res_fault(res_fault), .res_cause(res_cause),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .rsp_frame(mem_rsp_rdata[ADDR_W-1:OFF_W]),
    .acc_wr(acc_wr), .acc_usr(acc_usr),
    .dir_fault(dir_fault), .dir_cause(dir_cause),
    .dir_wb_need(dir_wb_need), .dir_wb_data(dir_wb_data),
    .tbl_fault(tbl_fault), .tbl_cause(tbl_cause),
    .tbl_wb_need(tbl_wb_need), .tbl_wb_data(tbl_wb_data)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               res_valid,
  input logic               res_ready,
  input logic [ADDR_W-1:0]  res_paddr,
  input logic               res_fault,
  input logic [CAUSE_W-1:0] res_cause,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic               mem_req_we,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic [ADDR_W-1:0]  mem_req_wdata,
  input logic               root_wr_en,
  input logic [ADDR_W-1:0]  root_wr_data,
  input logic [1:0]         cur_ring,
  input logic [ADDR_W-1:0]  root_q
);
  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr)
      && $stable(res_fault) && $stable(res_cause));

  p_busy_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || mem_req_valid) |-> !req_ready);

  p_wb_sets_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[FL_ACCESS]);

  p_ok_zero_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault |-> res_cause == '0);

  p_root_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    root_wr_en && cur_ring != 2'd0 |=> $stable(root_q));

  p_root_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    root_wr_en && cur_ring == 2'd0 |=> root_q == $past(root_wr_data));
endmodule

bind pt_walker pt_walker_chk u_walker_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
  .res_fault(res_fault), .res_cause(res_cause),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .root_wr_en(root_wr_en),
  .root_wr_data(root_wr_data), .cur_ring(cur_ring), .root_q(root_q)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_wr_en = 1'b0;
  logic [31:0] root_wr_data = '0;
  logic [1:0]  cur_ring = 2'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_paddr;
  logic        res_fault;
  logic [2:0]  res_cause;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (.*);

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] mem [4096];
  int          rd_cnt, wr_cnt;
  logic [31:0] rd_log [4];
  logic        stall_mode = 1'b0;

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_we;
    mem_rsp_rdata <= mem[mem_req_addr[13:2]];
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr[13:2]] <= mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        if (rd_cnt < 4) rd_log[rd_cnt] <= mem_req_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
    mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int k = 0; k < 4096; k++) mem[k] = '0;
    mem[12'h400] = 32'h0000_2007;  // dir0: P W U, accessed clear
    mem[12'h401] = 32'h0000_3025;  // dir1: P U A, read only
    mem[12'h403] = 32'h0000_2023;  // dir3: P W A, supervisor
    mem[12'h800] = 32'h0ABC_D007;
    mem[12'h801] = 32'h1234_5067;
    mem[12'h802] = 32'h5555_5027;
    mem[12'h804] = 32'h7777_7021;
    mem[12'hC00] = 32'h9999_9067;
  endtask

  task automatic set_root(input logic [31:0] v, input logic [1:0] ring);
    @(negedge clk);
    root_wr_en = 1'b1; root_wr_data = v; cur_ring = ring;
    @(negedge clk);
    root_wr_en = 1'b0; cur_ring = 2'd0;
  endtask

  logic        busy_seen;
  logic [31:0] got_pa;
  logic        got_flt;
  logic [2:0]  got_cause;

  task automatic do_walk(input logic [31:0] va, input logic w, input logic u, input int hold);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = !req_ready;
    while (!res_valid) @(negedge clk);
    got_pa = res_paddr; got_flt = res_fault; got_cause = res_cause;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check("R10 result held", {31'd0, res_valid}, 32'd1);
      check("R10 paddr stable", res_paddr, got_pa);
      check("R10 not ready while result pending", {31'd0, req_ready}, 32'd0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        usr;
    logic        flt;
    logic [2:0]  cause;
    logic [31:0] pa;
    logic [1:0]  nwr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1123, 1'b0, 1'b1, 1'b0, 3'b000, 32'h1234_5123, 2'd1},
    '{32'h0000_0456, 1'b1, 1'b1, 1'b0, 3'b000, 32'h0ABC_D456, 2'd2},
    '{32'h0000_2008, 1'b1, 1'b0, 1'b0, 3'b000, 32'h5555_5008, 2'd2},
    '{32'h0000_2FFF, 1'b0, 1'b0, 1'b0, 3'b000, 32'h5555_5FFF, 2'd1},
    '{32'h0040_0010, 1'b0, 1'b1, 1'b0, 3'b000, 32'h9999_9010, 2'd0},
    '{32'h0040_0010, 1'b1, 1'b1, 1'b1, 3'b111, 32'h0000_0000, 2'd0},
    '{32'h0080_0000, 1'b0, 1'b0, 1'b1, 3'b000, 32'h0000_0000, 2'd0},
    '{32'h00C0_4000, 1'b0, 1'b1, 1'b1, 3'b101, 32'h0000_0000, 2'd0},
    '{32'h00C0_40AB, 1'b1, 1'b0, 1'b0, 3'b000, 32'h7777_70AB, 2'd1},
    '{32'h0000_3000, 1'b0, 1'b1, 1'b1, 3'b100, 32'h0000_0000, 2'd0},
    '{32'h0000_4000, 1'b1, 1'b1, 1'b1, 3'b111, 32'h0000_0000, 2'd0},
    '{32'h0040_07FC, 1'b1, 1'b0, 1'b0, 3'b000, 32'h9999_97FC, 2'd0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    rd_cnt = 0; wr_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11 req_ready", {31'd0, req_ready}, 32'd1);
    check("R11 res_valid", {31'd0, res_valid}, 32'd0);
    check("R11 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    init_mem();
    do_walk(32'h0000_1123, 1'b0, 1'b0, 0);
    check("R11 root resets to zero", rd_log[0], 32'h0000_0000);

    set_root(32'h0000_1000, 2'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] dix, tix, tbase;
      init_mem();
      do_walk(VECS[i].va, VECS[i].wr, VECS[i].usr, 0);
      dix = {22'd0, VECS[i].va[31:22]};
      tix = {22'd0, VECS[i].va[21:12]};
      tbase = (dix == 32'd1) ? 32'h3000 : 32'h2000;
      check("R4/R5 fault flag", {31'd0, got_flt}, {31'd0, VECS[i].flt});
      check("R6 cause", {29'd0, got_cause}, {29'd0, VECS[i].cause});
      if (!VECS[i].flt) check("R3 physical address", got_pa, VECS[i].pa);
      check("R7/R8 write-back count", wr_cnt, {30'd0, VECS[i].nwr});
      check("R1 directory read address", rd_log[0], 32'h1000 + dix * 4);
      if (rd_cnt > 1) check("R2 table read address", rd_log[1], tbase + tix * 4);
    end

    // R7: written-back entry values and order of updates
    init_mem();
    do_walk(32'h0000_0456, 1'b1, 1'b1, 0);
    check("R7 directory accessed set", mem[12'h400], 32'h0000_2027);
    check("R7 table accessed and dirty set", mem[12'h800], 32'h0ABC_D067);
    init_mem();
    do_walk(32'h0000_2FFF, 1'b0, 1'b0, 0);
    check("R7 read leaves dirty clear", mem[12'h802], 32'h5555_5027);

    // R8: faulting walk leaves the directory entry untouched
    init_mem();
    do_walk(32'h0000_3000, 1'b0, 1'b1, 0);
    check("R8 no write on fault", mem[12'h400], 32'h0000_2007);
    check("R8 no write count", wr_cnt, 32'd0);

    // R9: ring 3 cannot move the directory base; ring 0 can
    init_mem();
    set_root(32'h0000_0000, 2'd3);
    do_walk(32'h0040_0010, 1'b0, 1'b1, 0);
    check("R9 ring3 root write ignored", rd_log[0], 32'h0000_1004);
    check("R9 translation still succeeds", got_pa, 32'h9999_9010);
    set_root(32'h0000_3000, 2'd0);
    do_walk(32'h0000_0000, 1'b0, 1'b0, 0);
    check("R9 ring0 root write taken", rd_log[0], 32'h0000_3000);
    set_root(32'h0000_1000, 2'd0);

    // R10/R12: stalled memory and stalled result consumer
    init_mem();
    stall_mode = 1'b1;
    do_walk(32'h0000_0456, 1'b1, 1'b1, 4);
    stall_mode = 1'b0;
    check("R10 busy after accept", {31'd0, busy_seen}, 32'd1);
    check("R12 paddr under stalls", got_pa, 32'h0ABC_D456);
    check("R12 write-backs under stalls", wr_cnt, 32'd2);
    check("R12 dirty under stalls", mem[12'h800], 32'h0ABC_D067);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule